// File: doc/BRIEF.md
# Transmit Heartbeat and Forced-Collision Monitor

This block runs next to a half-duplex Ethernet transmit engine. Once a frame has gone out, it opens a short listening window. During that window it watches the collision input for the signal-quality-test pulse that a healthy transceiver returns. If the pulse does not arrive before the window closes, it raises a heartbeat-lost flag. The transmit engine copies that flag into the frame's descriptor. While the window is open, a busy output stays high, so the engine can hold back its completion report until the result is settled.

For self-test in loopback, the block can also inject an artificial collision into every transmit attempt. The collision appears a fixed number of transmit clocks after the attempt starts. Every attempt therefore collides, and every frame eventually exhausts its retry limit. This exercises the collision, jam and retry paths of the surrounding logic. Time is counted only in transmit clock enable pulses.

Top module: `tx_sqe_monitor`

## Requirements
- R1: A `txEnd` strobe while `hbCheckEn` is 0 leaves `busy` low and drives `hbLost` to 0 on the next cycle. With checking disabled, `hbLost` is never set.
- R2: A `txEnd` strobe while `hbCheckEn` is 1 clears `hbLost` and raises `busy` from the next cycle.
- R3: The listening window advances only on cycles with `txClkEn` high. A `colIn` level on a cycle without `txClkEn` has no effect on `busy` or `hbLost`.
- R4: `colIn` sampled high together with the k-th `txClkEn` pulse of the window, for any k from 1 to HB_WINDOW (default 20), ends the window. After that edge `busy` is 0 and `hbLost` is 0.
- R5: If HB_WINDOW enable pulses pass with no sampled collision, `busy` falls and `hbLost` rises together, right after the last of them. A collision on a later pulse is not counted.
- R6: `hbLost` keeps its value while the block is idle, until the next `txEnd`.
- R7: A `txStart` strobe while `forceColEn` is 1 arms the injector. `forceCol` rises right after the FORCE_DELAY-th (default 8) `txClkEn` pulse that follows, and stays high until the next `txStart` or `txEnd`.
- R8: Every `txStart` drops `forceCol` on the next cycle and re-arms the count, so each retry attempt receives its own forced collision.
- R9: A `txStart` strobe while `forceColEn` is 0 leaves `forceCol` low for the whole attempt.
- R10: After reset, `busy`, `hbLost` and `forceCol` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txClkEn | input | 1 | One-cycle pulse per transmit bit clock |
| txStart | input | 1 | Strobe at the start of each transmit attempt |
| txEnd | input | 1 | Strobe when a frame's transmission ends |
| colIn | input | 1 | Collision level from the transceiver |
| hbCheckEn | input | 1 | Mode bit: enable heartbeat checking |
| forceColEn | input | 1 | Mode bit: inject a collision into every attempt |
| busy | output | 1 | High while the heartbeat window is open |
| hbLost | output | 1 | Heartbeat missing for the last frame |
| forceCol | output | 1 | Forced collision request to the transmit engine |

## Verification
The bench uses the default parameters: a 20-pulse listening window and an 8-pulse injection delay. At these values it can probe the window's edges directly: a collision on pulse 1, on pulse 20 and on pulse 21. Enable pulses are separated by idle cycles, which makes it possible to show that collision levels between pulses are ignored. The injection delay is short enough that several retries, each with its own re-armed collision, fit within one run.

// File: rtl/tx_sqe_pkg.sv
package tx_sqe_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic winClr;
    logic winInc;
    logic lostSet;
    logic lostClr;
    logic fcClr;
    logic fcInc;
    logic colSet;
    logic colClr;
  } sqeCtrl_t;

  typedef enum logic {
    WIN_IDLE   = 1'b0,
    WIN_LISTEN = 1'b1
  } winState_t;

  typedef enum logic [1:0] {
    FC_IDLE   = 2'd0,
    FC_ARMED  = 2'd1,
    FC_ACTIVE = 2'd2
  } fcState_t;

endpackage

// File: rtl/tx_sqe_datapath.sv
module tx_sqe_datapath
  import tx_sqe_pkg::*;
#(
  parameter int HB_WINDOW   = 20,
  parameter int FORCE_DELAY = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  sqeCtrl_t ctrl,
  output logic     winLast,
  output logic     fcLast,
  output logic     hbLost,
  output logic     forceCol
);

  localparam int WIN_W = $clog2(HB_WINDOW + 1);
  localparam int FC_W  = $clog2(FORCE_DELAY + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(HB_WINDOW - 1);
  localparam logic [FC_W-1:0]  FC_END  = FC_W'(FORCE_DELAY - 1);

  logic [WIN_W-1:0] winCnt;
  logic [FC_W-1:0]  fcCnt;

  // heartbeat window pulse counter
  always_ff @(posedge clk) begin
    if (!rstN)            winCnt <= '0;
    else if (ctrl.winClr) winCnt <= '0;
    else if (ctrl.winInc) winCnt <= winCnt + 1'b1;
  end

  // injection delay counter
  always_ff @(posedge clk) begin
    if (!rstN)           fcCnt <= '0;
    else if (ctrl.fcClr) fcCnt <= '0;
    else if (ctrl.fcInc) fcCnt <= fcCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             hbLost <= 1'b0;
    else if (ctrl.lostClr) hbLost <= 1'b0;
    else if (ctrl.lostSet) hbLost <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            forceCol <= 1'b0;
    else if (ctrl.colClr) forceCol <= 1'b0;
    else if (ctrl.colSet) forceCol <= 1'b1;
  end

  assign winLast = (winCnt == WIN_END);
  assign fcLast  = (fcCnt == FC_END);

endmodule

// File: rtl/tx_sqe_control.sv
module tx_sqe_control
  import tx_sqe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txClkEn,
  input  logic     txStart,
  input  logic     txEnd,
  input  logic     colIn,
  input  logic     hbCheckEn,
  input  logic     forceColEn,
  input  logic     winLast,
  input  logic     fcLast,
  output sqeCtrl_t ctrl,
  output logic     busy
);

  winState_t winState, winNext;
  fcState_t  fcState, fcNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winState <= WIN_IDLE;
      fcState  <= FC_IDLE;
    end else begin
      winState <= winNext;
      fcState  <= fcNext;
    end
  end

  always_comb begin
    ctrl    = '0;
    winNext = winState;
    fcNext  = fcState;

    // heartbeat window: a new end of frame always restarts it
    if (txEnd) begin
      ctrl.lostClr = 1'b1;
      if (hbCheckEn) begin
        ctrl.winClr = 1'b1;
        winNext     = WIN_LISTEN;
      end else begin
        winNext = WIN_IDLE;
      end
    end else if (winState == WIN_LISTEN && txClkEn) begin
      if (colIn) begin
        winNext = WIN_IDLE;
      end else if (winLast) begin
        ctrl.lostSet = 1'b1;
        winNext      = WIN_IDLE;
      end else begin
        ctrl.winInc = 1'b1;
      end
    end

    // collision injector: re-armed by every attempt
    if (txStart) begin
      ctrl.colClr = 1'b1;
      if (forceColEn) begin
        ctrl.fcClr = 1'b1;
        fcNext     = FC_ARMED;
      end else begin
        fcNext = FC_IDLE;
      end
    end else if (txEnd) begin
      ctrl.colClr = 1'b1;
      fcNext      = FC_IDLE;
    end else if (fcState == FC_ARMED && txClkEn) begin
      if (fcLast) begin
        ctrl.colSet = 1'b1;
        fcNext      = FC_ACTIVE;
      end else begin
        ctrl.fcInc = 1'b1;
      end
    end
  end

  assign busy = (winState == WIN_LISTEN);

endmodule

// File: rtl/tx_sqe_monitor.sv
module tx_sqe_monitor
  import tx_sqe_pkg::*;
#(
  parameter int HB_WINDOW   = 20,
  parameter int FORCE_DELAY = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic txClkEn,
  input  logic txStart,
  input  logic txEnd,
  input  logic colIn,
  input  logic hbCheckEn,
  input  logic forceColEn,
  output logic busy,
  output logic hbLost,
  output logic forceCol
);

  sqeCtrl_t ctrl;
  logic     winLast;
  logic     fcLast;

  tx_sqe_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txClkEn    (txClkEn),
    .txStart    (txStart),
    .txEnd      (txEnd),
    .colIn      (colIn),
    .hbCheckEn  (hbCheckEn),
    .forceColEn (forceColEn),
    .winLast    (winLast),
    .fcLast     (fcLast),
    .ctrl       (ctrl),
    .busy       (busy)
  );

  tx_sqe_datapath #(
    .HB_WINDOW   (HB_WINDOW),
    .FORCE_DELAY (FORCE_DELAY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .winLast  (winLast),
    .fcLast   (fcLast),
    .hbLost   (hbLost),
    .forceCol (forceCol)
  );

endmodule

// File: rtl/tx_sqe_monitor_checker.sv
module tx_sqe_monitor_checker (
  input logic clk,
  input logic rstN,
  input logic txClkEn,
  input logic txStart,
  input logic txEnd,
  input logic colIn,
  input logic hbCheckEn,
  input logic forceColEn,
  input logic busy,
  input logic hbLost,
  input logic forceCol
);

  p_busy_needs_mode_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txEnd && hbCheckEn));

  p_end_opens_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && hbCheckEn) |=> (busy && !hbLost));

  p_idle_gap_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txClkEn && !txEnd) |=> busy);

  p_col_closes_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txClkEn && colIn && !txEnd) |=> (!busy && !hbLost));

  p_lost_at_close_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbLost) |-> $fell(busy));

  p_lost_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !txEnd) |=> $stable(hbLost));

  p_force_on_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceCol) |-> $past(txClkEn));

  p_start_drops_force_r8: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !forceCol);

endmodule

bind tx_sqe_monitor tx_sqe_monitor_checker u_chk (.*);

// File: tb/tx_sqe_monitor_tb.sv
`timescale 1ns/1ps
module tx_sqe_monitor_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txClkEn = 1'b0, txStart = 1'b0, txEnd = 1'b0, colIn = 1'b0;
  logic hbCheckEn = 1'b0, forceColEn = 1'b0;
  logic busy, hbLost, forceCol;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tx_sqe_monitor u_dut (.*);

  // vector: {en, colAt, gapColAt, expLost, expEndPulse}
  localparam logic [16:0] VEC [7] = '{
    {1'b1, 5'd3,  5'd0, 1'b0, 5'd3},
    {1'b1, 5'd0,  5'd0, 1'b1, 5'd20},
    {1'b1, 5'd20, 5'd0, 1'b0, 5'd20},
    {1'b1, 5'd21, 5'd0, 1'b1, 5'd20},
    {1'b1, 5'd0,  5'd5, 1'b1, 5'd20},
    {1'b0, 5'd0,  5'd0, 1'b0, 5'd0},
    {1'b1, 5'd1,  5'd0, 1'b0, 5'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      txClkEn = 1'b1;
      @(negedge clk);
      txClkEn = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 hbLost", hbLost, 0);
    chk("R10 forceCol", forceCol, 0);

    // table walk: heartbeat window
    for (int v = 0; v < 7; v++) begin
      logic en, expLost;
      int colAt, gapAt, expEnd, endAt;
      en      = VEC[v][16];
      colAt   = int'(VEC[v][15:11]);
      gapAt   = int'(VEC[v][10:6]);
      expLost = VEC[v][5];
      expEnd  = int'(VEC[v][4:0]);
      endAt   = 0;
      hbCheckEn = en;
      txEnd = 1'b1;
      @(negedge clk);
      txEnd = 1'b0;
      chk(en ? "R2 busy after end" : "R1 busy stays low", busy, en);
      if (!en) chk("R1 hbLost cleared", hbLost, 0);
      if (en) begin
        for (int p = 1; p <= 25; p++) begin
          txClkEn = 1'b1;
          colIn   = (p == colAt);
          @(negedge clk);
          txClkEn = 1'b0;
          colIn   = (p == gapAt);
          if (!busy) begin
            colIn = 1'b0;
            endAt = p;
            break;
          end
          @(negedge clk);
          colIn = 1'b0;
        end
        chk(colAt != 0 && colAt <= 20 ? "R4 close pulse" : "R5 close pulse", endAt, expEnd);
        chk(gapAt != 0 ? "R3 gap collision ignored" : (expLost ? "R5 hbLost" : "R4 hbLost"),
            hbLost, expLost);
      end
      repeat (3) @(negedge clk);
      chk("R6 hbLost held", hbLost, expLost);
      chk("R6 busy idle", busy, 0);
    end

    // directed: forced collision
    hbCheckEn  = 1'b0;
    forceColEn = 1'b1;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    pulse(7);
    chk("R7 not before 8th pulse", forceCol, 0);
    pulse(1);
    chk("R7 asserted at 8th pulse", forceCol, 1);
    repeat (4) @(negedge clk);
    pulse(3);
    chk("R7 held", forceCol, 1);

    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    chk("R8 retry drops forceCol", forceCol, 0);
    pulse(7);
    chk("R8 retry not early", forceCol, 0);
    pulse(1);
    chk("R8 retry collides again", forceCol, 1);

    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    chk("R7 end clears forceCol", forceCol, 0);
    chk("R1 no window when disabled", busy, 0);

    forceColEn = 1'b0;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    pulse(12);
    chk("R9 no force when off", forceCol, 0);

    // reset in the middle of a window
    hbCheckEn = 1'b1;
    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    pulse(5);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R10 busy after reset", busy, 0);
    chk("R10 hbLost after reset", hbLost, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule